// File: doc/BRIEF.md
# Interrupt-Capable Register-Mapped GPIO Port

This block is a general-purpose I/O port of up to 32 pins, controlled through a small 32-bit word register interface. Software sets each pin's direction and output level. It reads back the pin states. It can program every pin to flag an interrupt on a high level, a low level, a rising edge, a falling edge, or on either edge. Pin inputs are synchronised to the port clock before any decision is taken on them.

Every trigger that fires sets a sticky per-pin pending bit. Software clears a pending bit by writing a one to the matching bit of the acknowledge register. A single interrupt line is raised whenever any pending pin is also enabled in the mask register. A raw-condition register shows the trigger state before the mask is applied. A read-only revision register reports a build-time value. The dual-edge register exists only when that value exceeds 2.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset the direction register reads all ones (every pin an input), and the output-enable vector is therefore 0. The data, mask, pending, trigger-type, polarity and dual-edge registers reset to 0, and `irq` is low.
- R2: Direction register (byte offset 0x04): a 1 bit makes the pin an input and drives `pin_oe` low for it. A 0 bit makes it an output: `pin_oe` is high and `pin_out` carries the data register (offset 0x00) bit. `pin_oe` changes only on a direction write.
- R3: Reading offset 0x00 returns the synchronised pin level for input pins and the stored drive level for output pins. Read data appears on `bus_rdata` after the clock edge at which `bus_rd` is high, and it holds otherwise.
- R4: When the trigger-type bit (offset 0x18) is 0, the pin is level-triggered: polarity bit (offset 0x1C) 1 means active high, 0 means active low. While the active level persists, the pending bit is set again every cycle, so an acknowledge in that cycle does not clear it.
- R5: When the trigger-type bit is 1 and the dual-edge bit is 0, polarity 1 sets pending on a rising edge only and polarity 0 on a falling edge only. The opposite transition sets nothing.
- R6: When the dual-edge bit (offset 0x24) and the trigger-type bit are both 1, either transition sets pending. In level mode the dual-edge bit has no effect.
- R7: Writing the acknowledge register (offset 0x14) clears each pending bit (read at offset 0x10) whose written bit is 1, and it leaves bits written 0 unchanged. A trigger in the same cycle as the clear wins.
- R8: `irq` is high exactly when some pin is both pending and enabled in the mask register (offset 0x08). With a mask of 0, `irq` stays low.
- R9: The raw-condition register (offset 0x0C) returns the current trigger condition per pin, independent of the mask.
- R10: The revision register (offset 0x20) returns the parameter VERSION and ignores writes. The dual-edge register is readable and writable only when VERSION > 2, and otherwise reads 0.
- R11: A pin change reaches the pending register, and so `irq`, on the third clock edge after it is applied: two synchroniser stages and then the pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | NPINS | Pin input levels (asynchronous) |
| pin_out | output | NPINS | Drive levels for output pins |
| pin_oe | output | NPINS | Output enable per pin |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench targets the places where trigger modes interact. It checks a level-active pin under an acknowledge: a design that lets the clear win would drop the pending bit while the level is still present. It checks the dual-edge bit left set on a level-mode pin: a design that honours it there would lose the steady re-assertion. It checks the wrong-direction edge on a single-edge pin, which a sloppy detector would latch. It also checks an acknowledge of one pin next to another pending pin, which a clear-all design would wipe, and it counts the exact edge on which `irq` first rises after a pin change, which an extra or a missing synchroniser stage would shift.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_AW = 6;
  typedef logic [3:0] widx_t;

  // word index = byte offset / 4
  localparam widx_t IDX_DATA = 4'd0;
  localparam widx_t IDX_DIR  = 4'd1;
  localparam widx_t IDX_MASK = 4'd2;
  localparam widx_t IDX_RAW  = 4'd3;
  localparam widx_t IDX_PEND = 4'd4;
  localparam widx_t IDX_ACK  = 4'd5;
  localparam widx_t IDX_MODE = 4'd6;
  localparam widx_t IDX_POL  = 4'd7;
  localparam widx_t IDX_REV  = 4'd8;
  localparam widx_t IDX_DUAL = 4'd9;

  // Trigger condition of one pin in the current cycle.
  function automatic logic pin_trigger(input logic is_edge, input logic pol,
                                       input logic dual, input logic cur,
                                       input logic prv);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (!is_edge) return pol ? cur : ~cur;
    if (dual) return rise | fall;
    return pol ? rise : fall;
  endfunction

  // Level seen when the data word is read back.
  function automatic logic pin_readback(input logic is_in, input logic synced,
                                        input logic drive);
    return is_in ? synced : drive;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stage1_q, stage2_q, stage3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      stage3_q <= '0;
    end else begin
      stage1_q <= raw_i;
      stage2_q <= stage1_q;
      stage3_q <= stage2_q;
    end
  end

  assign sync_o = stage2_q;
  assign prev_o = stage3_q;
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prv_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] dual_i,
  output logic [W-1:0] hit_o
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit_o[i] = gpio_irq_pkg::pin_trigger(mode_i[i], pol_i[i], dual_i[i],
                                                cur_i[i], prv_i[i]);
  end
endmodule

// File: rtl/gpio_pend_latch.sv
module gpio_pend_latch #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_en_i,
  input  logic [W-1:0] ack_bits_i,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] pend_o
);
  logic [W-1:0] pend_q, clr_mask;

  assign clr_mask = ack_en_i ? ack_bits_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_mask) | hit_i;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned VERSION = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [31:0]      bus_wdata,
  input  logic             bus_rd,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  import gpio_irq_pkg::*;

  localparam bit HAS_DUAL = (VERSION > 2);

  widx_t            widx;
  logic [NPINS-1:0] wbits;
  logic             wr_data, wr_dir, wr_mask, wr_ack, wr_mode, wr_pol, wr_dual;

  logic [NPINS-1:0] data_q, dir_q, mask_q, mode_q, pol_q, dual_q;
  logic [NPINS-1:0] pin_sync, pin_prev, trig_hit, pend_q, readback;
  logic [31:0]      rd_mux;
  logic             unused_ok;

  assign widx  = bus_addr[REG_AW-1:2];
  assign wbits = bus_wdata[NPINS-1:0];
  assign unused_ok = ^{bus_addr[1:0], bus_wdata};

  assign wr_data = bus_wr && (widx == IDX_DATA);
  assign wr_dir  = bus_wr && (widx == IDX_DIR);
  assign wr_mask = bus_wr && (widx == IDX_MASK);
  assign wr_ack  = bus_wr && (widx == IDX_ACK);
  assign wr_mode = bus_wr && (widx == IDX_MODE);
  assign wr_pol  = bus_wr && (widx == IDX_POL);
  assign wr_dual = bus_wr && (widx == IDX_DUAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '1;
      mask_q <= '0;
      mode_q <= '0;
      pol_q  <= '0;
    end else begin
      if (wr_data) data_q <= wbits;
      if (wr_dir)  dir_q  <= wbits;
      if (wr_mask) mask_q <= wbits;
      if (wr_mode) mode_q <= wbits;
      if (wr_pol)  pol_q  <= wbits;
    end
  end

  if (HAS_DUAL) begin : g_dual
    logic [NPINS-1:0] dual_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dual_r <= '0;
      else if (wr_dual) dual_r <= wbits;
    end
    assign dual_q = dual_r;
  end else begin : g_no_dual
    logic unused_dual;
    assign unused_dual = wr_dual;
    assign dual_q = '0;
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(pin_sync), .prev_o(pin_prev)
  );

  gpio_trig_detect #(.W(NPINS)) u_detect (
    .cur_i(pin_sync), .prv_i(pin_prev), .mode_i(mode_q), .pol_i(pol_q),
    .dual_i(dual_q), .hit_o(trig_hit)
  );

  gpio_pend_latch #(.W(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .ack_en_i(wr_ack), .ack_bits_i(wbits),
    .hit_i(trig_hit), .pend_o(pend_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_rb
    assign readback[i] = pin_readback(dir_q[i], pin_sync[i], data_q[i]);
  end

  always_comb begin
    rd_mux = '0;
    unique case (widx)
      IDX_DATA: rd_mux = 32'(readback);
      IDX_DIR:  rd_mux = 32'(dir_q);
      IDX_MASK: rd_mux = 32'(mask_q);
      IDX_RAW:  rd_mux = 32'(trig_hit);
      IDX_PEND: rd_mux = 32'(pend_q);
      IDX_MODE: rd_mux = 32'(mode_q);
      IDX_POL:  rd_mux = 32'(pol_q);
      IDX_REV:  rd_mux = 32'(VERSION);
      IDX_DUAL: rd_mux = 32'(dual_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  assign pin_out = data_q;
  assign pin_oe  = ~dir_q;
  assign irq     = |(pend_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int unsigned NPINS   = 32,
  parameter int unsigned VERSION = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       bus_addr,
  input logic             bus_wr,
  input logic [31:0]      bus_wdata,
  input logic             bus_rd,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] pin_oe,
  input logic             irq,
  input logic [NPINS-1:0] trig_hit,
  input logic [NPINS-1:0] pend_q,
  input logic [NPINS-1:0] mask_q
);
  import gpio_irq_pkg::*;

  // R2
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr[5:2] == IDX_DIR) |=> $stable(pin_oe));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[5:2] == IDX_ACK) |=>
      ((pend_q & $past(bus_wdata[NPINS-1:0] & ~trig_hit)) == '0));

  // R4
  hit_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit != '0) |=> ((pend_q & $past(trig_hit)) == $past(trig_hit)));

  // R8
  mask_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  // R10
  rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[5:2] == IDX_REV) |=> (bus_rdata == 32'(VERSION)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .pin_oe(pin_oe), .irq(irq), .trig_hit(trig_hit), .pend_q(pend_q),
  .mask_q(mask_q)
);

// File: tb/gpio_irq_port_test.sv
`timescale 1ns/1ps
module gpio_irq_port_test;
  localparam int NP = 32;
  localparam int REVV = 3;

  logic          clk = 0;
  logic          rst_n = 0;
  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out, pin_oe;
  logic          irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic rd_d = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .VERSION(REVV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  localparam logic [3:0] W_DATA = 0, W_DIR = 1, W_MASK = 2, W_RAW = 3, W_PEND = 4,
                         W_ACK = 5, W_MODE = 6, W_POL = 7, W_REV = 8, W_DUAL = 9;

  always @(posedge clk) rd_d <= bus_rd;

  // monitor: pops expected read results as the data comes out
  always @(negedge clk) begin
    if (rd_d) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = {idx, 2'b00}; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = {idx, 2'b00}; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pins(input logic [NP-1:0] v);
    @(negedge clk);
    pin_in = v;
    cyc(3);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    n_cmp++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act, e);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    cyc(4);
    rst_n = 1;
    @(negedge clk);
    chk(32'(pin_oe), 0, "R1 oe after reset");
    chk(32'(irq), 0, "R1 irq after reset");
    rd(W_DIR,  32'hFFFF_FFFF, "R1 dir reset");
    rd(W_MASK, 0, "R1 mask reset");
    rd(W_MODE, 0, "R1 mode reset");
    rd(W_DATA, 0, "R3 data all-input zero pins");
    rd(W_REV,  REVV, "R10 revision");
    // level-low default with pins low: everything pending
    rd(W_PEND, 32'hFFFF_FFFF, "R4 level-low pending");
    rd(W_RAW,  32'hFFFF_FFFF, "R9 raw level-low");
    wr(W_ACK, 32'hFFFF_FFFF);
    rd(W_PEND, 32'hFFFF_FFFF, "R4 level persists over ack");
    // all pins rising edge
    wr(W_MODE, 32'hFFFF_FFFF);
    wr(W_POL,  32'hFFFF_FFFF);
    wr(W_ACK,  32'hFFFF_FFFF);
    rd(W_PEND, 0, "R7 ack all");
    rd(W_RAW,  0, "R9 no edges");
    chk(32'(irq), 0, "R8 mask zero");
    // direction and data
    wr(W_DIR,  32'hFFFF_0000);
    wr(W_DATA, 32'h1234_ABCD);
    chk(32'(pin_oe), 32'h0000_FFFF, "R2 oe");
    chk(32'(pin_out), 32'h1234_ABCD, "R2 out");
    pins(32'hA5A5_5555);
    rd(W_DATA, 32'hA5A5_ABCD, "R3 mixed readback");
    pins(32'h0);
    wr(W_DIR, 32'hFFFF_FFFF);
    wr(W_ACK, 32'hFFFF_FFFF);
    rd(W_PEND, 0, "R5 falling ignored in rising mode");
    // mask
    wr(W_MASK, 32'h8);
    pins(32'h20);
    rd(W_PEND, 32'h20, "R5 rising pin5");
    chk(32'(irq), 0, "R8 unmasked pin quiet");
    pins(32'h28);
    chk(32'(irq), 1, "R8 masked pin fires");
    wr(W_ACK, 32'h8);
    chk(32'(irq), 0, "R7 irq drops on ack");
    rd(W_PEND, 32'h20, "R7 zero bits untouched");
    // falling on pin5
    wr(W_POL, 32'hFFFF_FFDF);
    wr(W_ACK, 32'hFFFF_FFFF);
    pins(32'h08);
    rd(W_PEND, 32'h20, "R5 falling pin5");
    wr(W_ACK, 32'hFFFF_FFFF);
    pins(32'h28);
    rd(W_PEND, 0, "R5 rising ignored in falling mode");
    // both edges
    wr(W_DUAL, 32'h20);
    rd(W_DUAL, 32'h20, "R10 dual readback");
    pins(32'h08);
    rd(W_PEND, 32'h20, "R6 dual fall");
    wr(W_ACK, 32'hFFFF_FFFF);
    pins(32'h28);
    rd(W_PEND, 32'h20, "R6 dual rise");
    // level-high with dual bit left set
    wr(W_MODE, 32'hFFFF_FFDF);
    wr(W_POL,  32'hFFFF_FFFF);
    wr(W_ACK,  32'h20);
    rd(W_PEND, 32'h20, "R6 dual ignored in level mode");
    rd(W_RAW,  32'h20, "R9 raw unmasked");
    chk(32'(irq), 0, "R9 raw does not drive irq");
    wr(W_MASK, 32'h20);
    chk(32'(irq), 1, "R8 enable pending pin");
    wr(W_REV, 32'hFFFF_FFFF);
    rd(W_REV, REVV, "R10 revision read-only");
    pins(32'h08);
    wr(W_ACK, 32'h20);
    rd(W_PEND, 0, "R4 level gone then cleared");
    chk(32'(irq), 0, "R8 nothing pending");
    // latency
    @(negedge clk);
    pin_in = 32'h28;
    @(negedge clk); chk(32'(irq), 0, "R11 edge1");
    @(negedge clk); chk(32'(irq), 0, "R11 edge2");
    @(negedge clk); chk(32'(irq), 1, "R11 edge3");
    cyc(3);
    chk(exp_q.size(), 0, "R3 all reads returned");
    report();
  end
endmodule